// File: doc/BRIEF.md
# Interrupt Priority Tracker

This block keeps three 256-bit arrays, one flag per interrupt vector: requested, in service and enabled. Interrupt sources raise a vector number; the request is kept only if that vector is enabled. Repeated raises of a vector that is already waiting fold into one request bit. The vector number alone sets priority, and the highest-numbered vector wins.

A processor-side consumer reads two results: the highest requested vector and a deliverable flag. The flag is set only when a request exists and the top request is strictly higher than the top in-service vector. When the consumer takes an interrupt, it acknowledges that vector, which moves it from requested to in service. When the handler finishes, an end-of-interrupt strobe retires the highest in-service vector. The enable array is written in 32-vector words. All outputs come from registered state through combinational priority encoders, so an update made on one clock edge is visible for the whole following cycle.

Top module: `intr_prio_tracker`

## Requirements
- R1: While `rst` is high on a clock edge, all request and in-service flags are cleared and all enable flags are set. After reset, `pend_o`, `req_any_o` and `svc_any_o` are 0, and `req_top_o` and `svc_top_o` read 0.
- R2: A raise of vector v sets request flag v only if enable flag v is set. A raise of a disabled vector leaves every request flag unchanged.
- R3: A raise of a vector whose request flag is already set has no further effect. One acknowledge of that vector clears all record of the request.
- R4: An enable write with `en_sel` = k loads the enable flags of vectors 32k to 32k+31, with bit i of `en_data` going to vector 32k+i. A raise in the same cycle as an enable write uses the enable value from before the write.
- R5: `req_any_o` is 1 when any request flag is set. `req_top_o` is then the highest-numbered set request flag. `svc_any_o` and `svc_top_o` report the in-service array in the same way.
- R6: `pend_o` is 1 exactly when a request exists and either nothing is in service or `req_top_o` is strictly greater than `svc_top_o`. An equal vector does not count as deliverable.
- R7: An acknowledge of vector v sets in-service flag v and clears request flag v on the same clock edge.
- R8: An end-of-interrupt clears only the highest set in-service flag. With nothing in service, it changes nothing.
- R9: Every output reflects all updates made on a clock edge during the cycle that follows that edge.
- R10: When a raise and an acknowledge name the same enabled vector in one cycle, the acknowledge is applied first. The raise then sets the request flag again, so both flags of that vector end up set.
- R11: When an end-of-interrupt and an acknowledge occur in one cycle, the end-of-interrupt acts on the in-service state from before the edge. The acknowledged flag is set afterwards, even if it is the one being retired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raise_valid | input | 1 | Raise request strobe |
| raise_vec | input | 8 | Vector being raised |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| eoi | input | 1 | End-of-interrupt strobe |
| en_wr | input | 1 | Enable word write strobe |
| en_sel | input | 3 | Enable word index (vectors 32k..32k+31) |
| en_data | input | 32 | Enable word value |
| pend_o | output | 1 | Top request outranks top in-service vector |
| req_any_o | output | 1 | At least one request flag set |
| req_top_o | output | 8 | Highest requested vector |
| svc_any_o | output | 1 | At least one in-service flag set |
| svc_top_o | output | 8 | Highest in-service vector |

## Verification
The bench targets these corner cases:

- **Equal top vectors.** A request matches the top in-service vector. A design that used greater-or-equal would assert `pend_o` here and nest an interrupt on itself.
- **Disabled raises and raises at enable-word edges.** These are vectors 224, 255 and 40. A wrong word or bit mapping would either drop a legal request or accept a masked one.
- **End-of-interrupt with two or more vectors in service, or with none.** A design that cleared the lowest bit, or every bit, would leave the wrong vector blocking lower requests.
- **Same-cycle collisions.** These are raise with acknowledge, and acknowledge with end-of-interrupt. A wrong ordering would lose a re-raised request or retire a vector that was just acknowledged.

Long random runs then compare all outputs against the bench's own model on every cycle.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    parameter int NUM_VEC   = 256;
    parameter int GRP_BITS  = 8;
    parameter int WORD_BITS = 32;

    localparam int VEC_W     = $clog2(NUM_VEC);
    localparam int NUM_WORDS = NUM_VEC / WORD_BITS;
    localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    typedef logic [VEC_W-1:0]   vec_t;
    typedef logic [NUM_VEC-1:0] vec_map_t;

    typedef struct packed {
        logic valid;
        vec_t vec;
    } vec_op_t;

    typedef struct packed {
        logic any;
        vec_t idx;
    } top_t;

    // enable word that contains a vector
    function automatic int word_of(input int v);
        return v / WORD_BITS;
    endfunction

    // bit position of a vector inside its enable word
    function automatic int lane_of(input int v);
        return v % WORD_BITS;
    endfunction

endpackage

// File: rtl/ipt_prio_enc.sv
module ipt_prio_enc #(
    parameter int N = 256,
    parameter int G = 8,
    localparam int IW  = $clog2(N),
    localparam int GW  = $clog2(G),
    localparam int NG  = N / G,
    localparam int NGW = $clog2(NG)
) (
    input  logic [N-1:0]  bits,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic [NG-1:0]    grp_any;
    logic [NG*GW-1:0] grp_idx;
    logic [NGW-1:0]   grp_sel;

    // first level: highest set bit inside each group
    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GW-1:0] loc;
        always_comb begin
            loc = '0;
            for (int b = 0; b < G; b++) begin
                if (bits[g*G + b]) loc = GW'(b);
            end
        end
        assign grp_any[g]            = |bits[g*G +: G];
        assign grp_idx[g*GW +: GW]   = loc;
    end

    // second level: highest group with any bit set
    always_comb begin
        grp_sel = '0;
        any     = 1'b0;
        for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) begin
                grp_sel = NGW'(g);
                any     = 1'b1;
            end
        end
    end

    assign idx = any ? {grp_sel, grp_idx[grp_sel*GW +: GW]} : '0;

endmodule

// File: rtl/ipt_arrays.sv
module ipt_arrays
    import ipt_pkg::*;
#(
    parameter int N  = NUM_VEC,
    parameter int WB = WORD_BITS,
    localparam int VW = $clog2(N),
    localparam int NW = N / WB,
    localparam int SW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raise_valid,
    input  logic [VW-1:0] raise_vec,
    input  logic          ack_valid,
    input  logic [VW-1:0] ack_vec,
    input  logic [N-1:0]  eoi_clr,
    input  logic          en_wr,
    input  logic [SW-1:0] en_sel,
    input  logic [WB-1:0] en_data,
    output logic [N-1:0]  req_q,
    output logic [N-1:0]  svc_q,
    output logic [N-1:0]  en_q
);

    for (genvar v = 0; v < N; v++) begin : g_slot
        localparam int WORD = v / WB;
        localparam int LANE = v % WB;

        logic r_bit, s_bit, e_bit;
        logic raise_hit, ack_hit, en_hit;

        assign raise_hit = raise_valid && (raise_vec == VW'(v));
        assign ack_hit   = ack_valid   && (ack_vec   == VW'(v));
        assign en_hit    = en_wr       && (en_sel    == SW'(WORD));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_bit <= 1'b0;
                s_bit <= 1'b0;
                e_bit <= 1'b1;
            end else begin
                // acknowledge first, then an enabled raise re-sets
                if (raise_hit && e_bit)  r_bit <= 1'b1;
                else if (ack_hit)        r_bit <= 1'b0;
                // end-of-interrupt first, then acknowledge sets
                if (ack_hit)             s_bit <= 1'b1;
                else if (eoi_clr[v])     s_bit <= 1'b0;
                if (en_hit)              e_bit <= en_data[LANE];
            end
        end

        assign req_q[v] = r_bit;
        assign svc_q[v] = s_bit;
        assign en_q[v]  = e_bit;
    end

endmodule

// File: rtl/intr_prio_tracker.sv
module intr_prio_tracker
    import ipt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        raise_valid,
    input  logic [7:0]  raise_vec,
    input  logic        ack_valid,
    input  logic [7:0]  ack_vec,
    input  logic        eoi,
    input  logic        en_wr,
    input  logic [2:0]  en_sel,
    input  logic [31:0] en_data,
    output logic        pend_o,
    output logic        req_any_o,
    output logic [7:0]  req_top_o,
    output logic        svc_any_o,
    output logic [7:0]  svc_top_o
);

    vec_map_t req_q, svc_q, en_q, eoi_clr;
    top_t     req_top, svc_top;
    vec_op_t  raise_op, ack_op;

    assign raise_op = '{valid: raise_valid, vec: raise_vec};
    assign ack_op   = '{valid: ack_valid,   vec: ack_vec};

    ipt_arrays #(.N(NUM_VEC), .WB(WORD_BITS)) u_arr (
        .clk         (clk),
        .rst         (rst),
        .raise_valid (raise_op.valid),
        .raise_vec   (raise_op.vec),
        .ack_valid   (ack_op.valid),
        .ack_vec     (ack_op.vec),
        .eoi_clr     (eoi_clr),
        .en_wr       (en_wr),
        .en_sel      (en_sel),
        .en_data     (en_data),
        .req_q       (req_q),
        .svc_q       (svc_q),
        .en_q        (en_q)
    );

    ipt_prio_enc #(.N(NUM_VEC), .G(GRP_BITS)) u_req_enc (
        .bits (req_q),
        .any  (req_top.any),
        .idx  (req_top.idx)
    );

    ipt_prio_enc #(.N(NUM_VEC), .G(GRP_BITS)) u_svc_enc (
        .bits (svc_q),
        .any  (svc_top.any),
        .idx  (svc_top.idx)
    );

    // one-hot retire mask for the highest in-service vector
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_eoi
        assign eoi_clr[v] = eoi && svc_top.any && (svc_top.idx == VEC_W'(v));
    end

    assign pend_o    = req_top.any && (!svc_top.any || (req_top.idx > svc_top.idx));
    assign req_any_o = req_top.any;
    assign req_top_o = req_top.idx;
    assign svc_any_o = svc_top.any;
    assign svc_top_o = svc_top.idx;

    // R7: acknowledge lands in the in-service array
    a_r7_ack_sets_svc: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> svc_q[$past(ack_vec)]);

    // R7: acknowledge clears the request unless re-raised
    a_r7_ack_clears_req: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !(raise_valid && raise_vec == ack_vec) |=> !req_q[$past(ack_vec)]);

    // R10: same-vector raise and acknowledge leave both flags set
    a_r10_raise_after_ack: assert property (@(posedge clk) disable iff (rst)
        ack_valid && raise_valid && raise_vec == ack_vec && en_q[raise_vec]
        |=> req_q[$past(raise_vec)] && svc_q[$past(raise_vec)]);

    // R2: raise of a disabled idle vector is dropped
    a_r2_masked_drop: assert property (@(posedge clk) disable iff (rst)
        raise_valid && !en_q[raise_vec] && !req_q[raise_vec] |=> !req_q[$past(raise_vec)]);

    // R8: end-of-interrupt retires exactly one vector
    a_r8_eoi_one: assert property (@(posedge clk) disable iff (rst)
        eoi && svc_any_o && !ack_valid
        |=> $countones(svc_q) == $countones($past(svc_q)) - 1);

    // R8: end-of-interrupt with nothing in service changes nothing
    a_r8_eoi_empty: assert property (@(posedge clk) disable iff (rst)
        eoi && !svc_any_o && !ack_valid |=> !svc_any_o);

    // R5: reported top request is a set flag
    a_r5_top_is_set: assert property (@(posedge clk) disable iff (rst)
        req_any_o |-> req_q[req_top_o]);

    // R6: never deliverable at or below the in-service level
    a_r6_strict_rank: assert property (@(posedge clk) disable iff (rst)
        pend_o |-> !(svc_any_o && svc_top_o >= req_top_o));

endmodule

// File: tb/sim_intr_prio_tracker.sv
`timescale 1ns/1ps
module sim_intr_prio_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raise_valid = 1'b0;
    logic [7:0]  raise_vec = '0;
    logic        ack_valid = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        eoi = 1'b0;
    logic        en_wr = 1'b0;
    logic [2:0]  en_sel = '0;
    logic [31:0] en_data = '0;
    logic        pend_o, req_any_o, svc_any_o;
    logic [7:0]  req_top_o, svc_top_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    started = 1'b0;
    bit    done = 1'b0;

    bit m_req [256];
    bit m_svc [256];
    bit m_en  [256];

    always #2 clk = ~clk;

    intr_prio_tracker u0 (
        .clk(clk), .rst(rst),
        .raise_valid(raise_valid), .raise_vec(raise_vec),
        .ack_valid(ack_valid), .ack_vec(ack_vec),
        .eoi(eoi), .en_wr(en_wr), .en_sel(en_sel), .en_data(en_data),
        .pend_o(pend_o), .req_any_o(req_any_o), .req_top_o(req_top_o),
        .svc_any_o(svc_any_o), .svc_top_o(svc_top_o)
    );

    function automatic int top_of(input bit a [256]);
        int t = -1;
        for (int i = 0; i < 256; i++) if (a[i]) t = i;
        return t;
    endfunction

    // behavioural reference model, updated on each edge
    always @(posedge clk) begin
        bit nr [256];
        bit ns [256];
        int st;
        started = 1'b1;
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                m_req[i] = 0; m_svc[i] = 0; m_en[i] = 1;
            end
        end else begin
            nr = m_req; ns = m_svc;
            st = top_of(m_svc);
            if (eoi && st >= 0) ns[st] = 0;
            if (ack_valid) begin ns[ack_vec] = 1; nr[ack_vec] = 0; end
            if (raise_valid && m_en[raise_vec]) nr[raise_vec] = 1;
            if (en_wr)
                for (int b = 0; b < 32; b++) m_en[en_sel*32 + b] = en_data[b];
            m_req = nr; m_svc = ns;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        int rt, stp;
        logic      e_pend, e_rany, e_sany;
        logic [7:0] e_rtop, e_stop;
        if (started && !done) begin
            rt  = top_of(m_req);
            stp = top_of(m_svc);
            e_rany = (rt >= 0);
            e_sany = (stp >= 0);
            e_rtop = e_rany ? 8'(rt) : 8'd0;
            e_stop = e_sany ? 8'(stp) : 8'd0;
            e_pend = e_rany && (!e_sany || rt > stp);
            n_chk++;
            if ({pend_o, req_any_o, req_top_o, svc_any_o, svc_top_o} !==
                {e_pend, e_rany, e_rtop, e_sany, e_stop}) begin
                n_bad++;
                $display("FAIL %s t=%0t pend/rany/rtop/sany/stop actual %0b/%0b/%0d/%0b/%0d expected %0b/%0b/%0d/%0b/%0d",
                         tag, $time, pend_o, req_any_o, req_top_o, svc_any_o, svc_top_o,
                         e_pend, e_rany, e_rtop, e_sany, e_stop);
            end
        end
    end

    task automatic step(input bit rv, input int rvec, input bit av, input int avec,
                        input bit eo, input bit ew, input int es, input logic [31:0] ed);
        @(negedge clk);
        raise_valid = rv; raise_vec = 8'(rvec);
        ack_valid   = av; ack_vec   = 8'(avec);
        eoi = eo; en_wr = ew; en_sel = 3'(es); en_data = ed;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 32'h0);
    endtask

    task automatic raise(input int v);  step(1, v, 0, 0, 0, 0, 0, 32'h0); endtask
    task automatic ack(input int v);    step(0, 0, 1, v, 0, 0, 0, 32'h0); endtask
    task automatic end_int();           step(0, 0, 0, 0, 1, 0, 0, 32'h0); endtask
    task automatic en_word(input int k, input logic [31:0] d); step(0, 0, 0, 0, 0, 1, k, d); endtask

    task automatic drain();
        for (int i = 0; i < 300 && (req_any_o || svc_any_o); i++) begin
            if (req_any_o) ack(int'(req_top_o)); else end_int();
            idle(1);
            while (svc_any_o) begin end_int(); idle(1); end
        end
    endtask

    initial begin
        // R1: reset values
        tag = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        idle(2);

        // R2: enabled raise kept, disabled raise dropped
        tag = "R2";
        raise(5); idle(1);
        en_word(1, ~(32'h1 << 8));
        raise(40); idle(1);
        raise(41); idle(1);

        // R4: word mapping and old-enable ordering at word edges
        tag = "R4";
        en_word(7, 32'h0);
        raise(255); raise(224); idle(1);
        step(1, 250, 0, 0, 0, 1, 7, 32'hFFFF_FFFF); idle(1);
        raise(255); idle(1);

        // R5: highest request across patterns
        tag = "R5";
        raise(100); raise(3); raise(200); idle(1);

        // R7 / R6: acknowledge, then equal and lower requests
        tag = "R7";
        ack(255); idle(1);
        tag = "R6";
        raise(250); idle(1);
        raise(255); idle(1);

        // R8: retire highest only, and with nothing in service
        tag = "R8";
        end_int(); idle(1);
        ack(255); ack(41); idle(1);
        end_int(); idle(1);
        end_int(); idle(1);
        end_int(); end_int(); idle(1);

        // R3: coalescing
        tag = "R3";
        drain();
        raise(77); raise(77); raise(77); idle(1);
        ack(77); idle(1);
        end_int(); idle(1);

        // R10: same-cycle raise and acknowledge
        tag = "R10";
        raise(90); idle(1);
        step(1, 90, 1, 90, 0, 0, 0, 32'h0); idle(1);
        end_int(); idle(1);

        // R11: same-cycle end-of-interrupt and acknowledge
        tag = "R11";
        drain();
        raise(60); raise(30); idle(1);
        ack(60); idle(1);
        step(0, 0, 1, 30, 1, 0, 0, 32'h0); idle(1);
        step(0, 0, 1, 30, 1, 0, 0, 32'h0); idle(1);

        // R9: random traffic, one-cycle visibility checked every cycle
        tag = "R9";
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom % 100;
            bit rv = ($urandom % 3) == 0;
            int rvec = (($urandom % 4) == 0) ? ($urandom % 8) * 32 + 31 : $urandom % 256;
            bit av = r < 20;
            int avec = (req_any_o && ($urandom % 2)) ? int'(req_top_o) : $urandom % 256;
            bit eo = r >= 70 && r < 90;
            bit ew = ($urandom % 40) == 0;
            logic [31:0] ed = (($urandom % 2) == 0) ? 32'hFFFF_FFFF : 32'($urandom);
            step(rv, rvec, av, avec, eo, ew, $urandom % 8, ed);
        end
        idle(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog expired in %s", tag);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule